// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical address for a processor whose memory space is 1 MB. The segment value is shifted left by four bits and added to the offset. The carry out of bit 19 is dropped, so addresses wrap around modulo 1 MB. The block holds the four segment registers: code, data, stack and extra. It also holds the two string pointers, source and destination.

Each request carries an access kind, and the block picks the segment that belongs to that kind. An instruction fetch and a stack access take their offset from the request, which carries the instruction pointer or the stack pointer. A string access takes its offset from the source pointer or the destination pointer kept inside the block. After a string access, the pointer that was used moves by one (byte) or two (word). It counts up when the direction flag is clear and down when the flag is set.

The code segment is protected. The ordinary segment write port cannot change it; only a separate control-transfer load port can. The physical address appears one clock after the request, together with a valid strobe.

Top module: `seg_addr_gen`

## Requirements
- R1: `physAddr` equals (segment × 16 + offset) mod 2^20. It is registered: `addrValid` is high in the cycle after an accepted request (`reqValid`=1) and low in the cycle after a cycle with no request.
- R2: Fetch requests (`reqKind`=0) use the code segment, with `reqOffset` as the offset.
- R3: Stack requests (`reqKind`=1) use the stack segment, with `reqOffset` as the offset.
- R4: String-source requests (`reqKind`=2) use the data segment, with the source pointer as the offset. `reqOffset` is ignored.
- R5: String-destination requests (`reqKind`=3) use the extra segment, with the destination pointer as the offset. `reqOffset` is ignored.
- R6: After a string request, the pointer it used changes by 1 when `reqWide`=0 and by 2 when `reqWide`=1. It goes up when `dirFlag`=0 and down when `dirFlag`=1, modulo 2^16. The other pointer keeps its value.
- R7: A segment-port write with `segWrSel`=0 (code) has no effect. `csLoadEn` writes `csLoadData` into the code segment. Segment selector codes are 1=data, 2=stack, 3=extra.
- R8: After reset, the code segment holds FFFFh, every other segment and both pointers hold 0, and `addrValid` is 0.
- R9: A sum that goes past FFFFFh wraps. For example, code segment FFFFh with offset FFFFh gives 0FFEFh.
- R10: A segment or pointer write is seen by requests in later cycles only; a request in the same cycle uses the old value. If a pointer write and a step of the same pointer fall in one cycle, the written value wins. Pointer selector codes are 0=source, 1=destination.
- R11: `siOut` and `diOut` always show the current source and destination pointer registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Address request this cycle |
| reqKind | input | 2 | 0 fetch, 1 stack, 2 string source, 3 string destination |
| reqWide | input | 1 | String step size: 0 byte, 1 word |
| reqOffset | input | 16 | Offset for fetch and stack requests |
| dirFlag | input | 1 | 1 makes string pointers count down |
| segWrEn | input | 1 | Segment write strobe |
| segWrSel | input | 2 | Segment to write; code 0 is refused |
| segWrData | input | 16 | Segment write value |
| csLoadEn | input | 1 | Control-transfer load of the code segment |
| csLoadData | input | 16 | New code segment value |
| ptrWrEn | input | 1 | String pointer write strobe |
| ptrWrSel | input | 1 | 0 source, 1 destination |
| ptrWrData | input | 16 | Pointer write value |
| addrValid | output | 1 | `physAddr` holds a new address |
| physAddr | output | 20 | Physical address |
| siOut | output | 16 | Source pointer |
| diOut | output | 16 | Destination pointer |

## Verification
The hardest cases to reach from the ports are the ones where several things happen in one cycle. A string step can collide with a pointer write to the same pointer, and a segment write can land in the same cycle as a request that reads that segment. Random traffic rarely makes these line up, so directed sequences set each one up deliberately. Directed sequences also drive the pointer wrap below zero and above FFFFh, and the 20-bit address wrap with the code segment at FFFFh. Long seeded random runs mix every access kind, step size and direction with writes to the segment and pointer ports, and a bench model predicts every address and pointer value.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_STACK = 2'd1,
    KIND_SRC   = 2'd2,
    KIND_DST   = 2'd3
  } accKind_t;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } segSel_t;

  localparam int NUM_SEGS = 4;
  localparam int NUM_PTRS = 2;

  typedef struct packed {
    logic    capture;
    segSel_t segSel;
    logic    useSi;
    logic    useDi;
    logic    stepSi;
    logic    stepDi;
    logic    down;
    logic    wide;
  } ctrlStrobe_t;

endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  input  logic        reqWide,
  input  logic        dirFlag,
  output ctrlStrobe_t strobe
);

  accKind_t kind;
  assign kind = accKind_t'(reqKind);

  always_comb begin
    strobe         = '0;
    strobe.capture = reqValid;
    strobe.down    = dirFlag;
    strobe.wide    = reqWide;
    strobe.segSel  = SEG_CODE;
    unique case (kind)
      KIND_FETCH: strobe.segSel = SEG_CODE;
      KIND_STACK: strobe.segSel = SEG_STACK;
      KIND_SRC: begin
        strobe.segSel = SEG_DATA;
        strobe.useSi  = 1'b1;
        strobe.stepSi = reqValid;
      end
      KIND_DST: begin
        strobe.segSel = SEG_EXTRA;
        strobe.useDi  = 1'b1;
        strobe.stepDi = reqValid;
      end
      default: strobe.segSel = SEG_CODE;
    endcase
  end

endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import seg_addr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter logic [DATA_W-1:0] CS_RESET = '1,
  localparam int ADDR_W = DATA_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] reqOffset,
  input  logic              segWrEn,
  input  logic [1:0]        segWrSel,
  input  logic [DATA_W-1:0] segWrData,
  input  logic              csLoadEn,
  input  logic [DATA_W-1:0] csLoadData,
  input  logic              ptrWrEn,
  input  logic              ptrWrSel,
  input  logic [DATA_W-1:0] ptrWrData,
  output logic              addrValid,
  output logic [ADDR_W-1:0] physAddr,
  output logic [DATA_W-1:0] siOut,
  output logic [DATA_W-1:0] diOut
);

  logic [DATA_W-1:0] segReg [NUM_SEGS];
  logic [DATA_W-1:0] ptrReg [NUM_PTRS];
  logic [DATA_W-1:0] stepAmt;

  assign stepAmt = strobe.wide ? DATA_W'(2) : DATA_W'(1);

  // Segment registers: the code slot only listens to the load port
  for (genvar s = 0; s < NUM_SEGS; s++) begin : gSeg
    if (s == int'(SEG_CODE)) begin : gCode
      always_ff @(posedge clk) begin
        if (!rstN)         segReg[s] <= CS_RESET;
        else if (csLoadEn) segReg[s] <= csLoadData;
      end
    end else begin : gPlain
      always_ff @(posedge clk) begin
        if (!rstN)                               segReg[s] <= '0;
        else if (segWrEn && segWrSel == 2'(s))   segReg[s] <= segWrData;
      end
    end
  end

  // String pointers: explicit write wins over a step
  for (genvar p = 0; p < NUM_PTRS; p++) begin : gPtr
    logic stepHere;
    assign stepHere = (p == 0) ? strobe.stepSi : strobe.stepDi;
    always_ff @(posedge clk) begin
      if (!rstN)                                ptrReg[p] <= '0;
      else if (ptrWrEn && ptrWrSel == 1'(p))    ptrReg[p] <= ptrWrData;
      else if (stepHere)
        ptrReg[p] <= strobe.down ? ptrReg[p] - stepAmt : ptrReg[p] + stepAmt;
    end
  end

  logic [DATA_W-1:0] offMux;
  logic [DATA_W-1:0] segVal;
  logic [ADDR_W-1:0] sumAddr;

  always_comb begin
    if (strobe.useSi)      offMux = ptrReg[0];
    else if (strobe.useDi) offMux = ptrReg[1];
    else                   offMux = reqOffset;
  end

  assign segVal  = segReg[strobe.segSel];
  assign sumAddr = {segVal, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offMux};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      physAddr  <= '0;
    end else begin
      addrValid <= strobe.capture;
      if (strobe.capture) physAddr <= sumAddr;
    end
  end

  assign siOut = ptrReg[0];
  assign diOut = ptrReg[1];

  // R7: the segment port never moves the code segment
  assert_cs_guard_R7: assert property (@(posedge clk) disable iff (!rstN)
    (segWrEn && segWrSel == 2'(SEG_CODE) && !csLoadEn) |=> $stable(segReg[0]));

  // R6: source pointer counting up
  assert_si_up_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepSi && !strobe.down && !(ptrWrEn && !ptrWrSel))
      |=> ptrReg[0] == DATA_W'($past(ptrReg[0]) + $past(stepAmt)));

  // R6: destination pointer counting down
  assert_di_down_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepDi && strobe.down && !(ptrWrEn && ptrWrSel))
      |=> ptrReg[1] == DATA_W'($past(ptrReg[1]) - $past(stepAmt)));

  // R10: a pointer write overrides a step that lands in the same cycle
  assert_wr_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ptrWrEn && !ptrWrSel) |=> ptrReg[0] == $past(ptrWrData));

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEG_SHIFT = 4,
  localparam int ADDR_W = DATA_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              reqWide,
  input  logic [DATA_W-1:0] reqOffset,
  input  logic              dirFlag,
  input  logic              segWrEn,
  input  logic [1:0]        segWrSel,
  input  logic [DATA_W-1:0] segWrData,
  input  logic              csLoadEn,
  input  logic [DATA_W-1:0] csLoadData,
  input  logic              ptrWrEn,
  input  logic              ptrWrSel,
  input  logic [DATA_W-1:0] ptrWrData,
  output logic              addrValid,
  output logic [ADDR_W-1:0] physAddr,
  output logic [DATA_W-1:0] siOut,
  output logic [DATA_W-1:0] diOut
);

  ctrlStrobe_t strobe;

  seg_addr_ctrl uCtrl (
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .reqWide  (reqWide),
    .dirFlag  (dirFlag),
    .strobe   (strobe)
  );

  seg_addr_dp #(
    .DATA_W    (DATA_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqOffset  (reqOffset),
    .segWrEn    (segWrEn),
    .segWrSel   (segWrSel),
    .segWrData  (segWrData),
    .csLoadEn   (csLoadEn),
    .csLoadData (csLoadData),
    .ptrWrEn    (ptrWrEn),
    .ptrWrSel   (ptrWrSel),
    .ptrWrData  (ptrWrData),
    .addrValid  (addrValid),
    .physAddr   (physAddr),
    .siOut      (siOut),
    .diOut      (diOut)
  );

  // R1: the valid strobe follows the request by one cycle
  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> addrValid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !addrValid);

  // R4: a source request leaves the destination pointer alone unless written
  assert_src_keeps_di_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd2 && !ptrWrEn) |=> $stable(diOut));

endmodule

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWide, dirFlag;
  logic [1:0]  reqKind;
  logic [15:0] reqOffset;
  logic        segWrEn, csLoadEn, ptrWrEn, ptrWrSel;
  logic [1:0]  segWrSel;
  logic [15:0] segWrData, csLoadData, ptrWrData;
  logic        addrValid;
  logic [19:0] physAddr;
  logic [15:0] siOut, diOut;

  always #5 clk = ~clk;

  seg_addr_gen uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqWide(reqWide), .reqOffset(reqOffset), .dirFlag(dirFlag),
    .segWrEn(segWrEn), .segWrSel(segWrSel), .segWrData(segWrData),
    .csLoadEn(csLoadEn), .csLoadData(csLoadData), .ptrWrEn(ptrWrEn),
    .ptrWrSel(ptrWrSel), .ptrWrData(ptrWrData), .addrValid(addrValid),
    .physAddr(physAddr), .siOut(siOut), .diOut(diOut)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [15:0] mSeg [4];
  logic [15:0] mPtr [2];

  task automatic chk(string tag, string what, int unsigned act, int unsigned exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int segOf(logic [1:0] kind);
    case (kind)
      2'd0: return 0;
      2'd1: return 2;
      2'd2: return 1;
      default: return 3;
    endcase
  endfunction

  function automatic logic [19:0] formAddr(logic [15:0] seg, logic [15:0] off);
    logic [19:0] a;
    a = {seg, 4'h0};
    a = a + {4'h0, off};
    return a;
  endfunction

  function automatic string kindTag(logic [1:0] kind);
    case (kind)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // One cycle: drive at negedge, update model, check at next negedge
  task automatic step(input logic v, input logic [1:0] kind, input logic wide,
                      input logic [15:0] off, input logic dir,
                      input logic sWr, input logic [1:0] sSel, input logic [15:0] sData,
                      input logic cLd, input logic [15:0] cData,
                      input logic pWr, input logic pSel, input logic [15:0] pData,
                      input string aTag, input string pTag);
    logic [19:0] expAddr;
    logic [15:0] offUse, amt;
    reqValid = v; reqKind = kind; reqWide = wide; reqOffset = off; dirFlag = dir;
    segWrEn = sWr; segWrSel = sSel; segWrData = sData;
    csLoadEn = cLd; csLoadData = cData;
    ptrWrEn = pWr; ptrWrSel = pSel; ptrWrData = pData;
    offUse = (kind == 2'd2) ? mPtr[0] : (kind == 2'd3) ? mPtr[1] : off;
    expAddr = formAddr(mSeg[segOf(kind)], offUse);
    if (cLd) mSeg[0] = cData;
    if (sWr && sSel != 2'd0) mSeg[sSel] = sData;
    amt = wide ? 16'd2 : 16'd1;
    for (int p = 0; p < 2; p++) begin
      if (pWr && pSel == 1'(p)) mPtr[p] = pData;
      else if (v && kind == ((p == 0) ? 2'd2 : 2'd3))
        mPtr[p] = dir ? mPtr[p] - amt : mPtr[p] + amt;
    end
    @(negedge clk);
    chk("R1", "addrValid", addrValid, v);
    if (v) chk((aTag != "") ? aTag : kindTag(kind), "physAddr", physAddr, expAddr);
    chk((pTag != "") ? pTag : "R11", "siOut", siOut, mPtr[0]);
    chk((pTag != "") ? pTag : "R11", "diOut", diOut, mPtr[1]);
  endtask

  task automatic req(logic [1:0] kind, logic wide, logic [15:0] off, logic dir,
                     string aTag, string pTag);
    step(1'b1, kind, wide, off, dir, 1'b0, 2'd0, 16'h0, 1'b0, 16'h0,
         1'b0, 1'b0, 16'h0, aTag, pTag);
  endtask

  task automatic segWrite(logic [1:0] sel, logic [15:0] d, string tag);
    step(1'b0, 2'd0, 1'b0, 16'h0, 1'b0, 1'b1, sel, d, 1'b0, 16'h0,
         1'b0, 1'b0, 16'h0, tag, tag);
  endtask

  task automatic ptrWrite(logic sel, logic [15:0] d, string tag);
    step(1'b0, 2'd0, 1'b0, 16'h0, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 16'h0,
         1'b1, sel, d, tag, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rstN = 1'b0;
    reqValid = 0; reqKind = 0; reqWide = 0; reqOffset = 0; dirFlag = 0;
    segWrEn = 0; segWrSel = 0; segWrData = 0; csLoadEn = 0; csLoadData = 0;
    ptrWrEn = 0; ptrWrSel = 0; ptrWrData = 0;
    mSeg[0] = 16'hFFFF; mSeg[1] = 0; mSeg[2] = 0; mSeg[3] = 0;
    mPtr[0] = 0; mPtr[1] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk("R8", "addrValid", addrValid, 0);
    chk("R8", "siOut", siOut, 0);
    chk("R8", "diOut", diOut, 0);
    req(2'd0, 1'b0, 16'h0000, 1'b0, "R8", "R8");   // FFFF0
    req(2'd1, 1'b0, 16'h1234, 1'b0, "R8", "R8");   // 01234
    req(2'd3, 1'b0, 16'h0000, 1'b0, "R8", "R8");   // 00000, DI -> 1

    // R10: segment write seen only by later requests
    step(1'b1, 2'd2, 1'b0, 16'hAAAA, 1'b0, 1'b1, 2'd1, 16'h1234, 1'b0, 16'h0,
         1'b0, 1'b0, 16'h0, "R10", "R10");
    req(2'd2, 1'b0, 16'h5555, 1'b0, "R4", "R6");    // 12341

    // R7: code segment protected from the segment port
    segWrite(2'd0, 16'h0000, "R7");
    req(2'd0, 1'b0, 16'h0010, 1'b0, "R7", "R11");   // 00000 wrap? FFFF0+10
    step(1'b0, 2'd0, 1'b0, 16'h0, 1'b0, 1'b0, 2'd0, 16'h0, 1'b1, 16'h1000,
         1'b0, 1'b0, 16'h0, "R7", "R7");
    req(2'd0, 1'b0, 16'h0020, 1'b0, "R7", "R11");   // 10020

    // R9: carry out of bit 19 discarded
    step(1'b0, 2'd0, 1'b0, 16'h0, 1'b0, 1'b0, 2'd0, 16'h0, 1'b1, 16'hFFFF,
         1'b0, 1'b0, 16'h0, "R9", "R9");
    req(2'd0, 1'b0, 16'hFFFF, 1'b0, "R9", "R11");   // 0FFEF

    // R6: pointer wrap in both directions
    ptrWrite(1'b0, 16'h0000, "R10");
    req(2'd2, 1'b0, 16'h0, 1'b1, "R4", "R6");       // SI -> FFFF
    req(2'd2, 1'b1, 16'h0, 1'b0, "R4", "R6");       // SI -> 0001
    req(2'd2, 1'b1, 16'h0, 1'b1, "R4", "R6");       // SI -> FFFF

    // R10: pointer write beats a same-cycle step
    step(1'b1, 2'd3, 1'b1, 16'h0, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 16'h0,
         1'b1, 1'b1, 16'h0050, "R5", "R10");
    segWrite(2'd3, 16'h8000, "R5");
    req(2'd3, 1'b1, 16'h7777, 1'b1, "R5", "R6");    // 80050, DI -> 4E
    segWrite(2'd2, 16'h2000, "R3");
    req(2'd1, 1'b0, 16'hFFFE, 1'b0, "R3", "R11");   // 2FFFE

    // Seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) != 0, 2'($urandom), 1'($urandom), 16'($urandom),
           1'($urandom), ($urandom % 5) == 0, 2'($urandom), 16'($urandom),
           ($urandom % 11) == 0, 16'($urandom),
           ($urandom % 7) == 0, 1'($urandom), 16'($urandom), "", "");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule